// File: doc/BRIEF.md
# Update-Based Three-State Coherence Controller

This block keeps the tag and state arrays of four private, direct-mapped, write-back caches and applies one memory operation per clock. An operation names the requesting processor, read or write, and a word address. The requester's line moves according to an update-based protocol with three states: Modified, Exclusive and Shared. All other caches snoop the same operation in the same cycle. No line is ever invalidated. Instead, a write to a shared line is broadcast as an update, and the remote copies stay valid.

A wired-OR shared signal is raised when the requester misses and at least one other cache holds the line. This signal decides whether the requester fills the line as Shared, or as Exclusive or Modified. Four running counters record misses, update broadcasts, remote lines updated and data messages. Data messages are write-backs on eviction and data writes on a snooped downgrade from Modified. A query port reads the tag and state of any line in any cache, combinationally. Data contents, transient states and split transactions are not modelled. Every operation completes in the cycle in which it is presented.

Top module: `mes_coherence`

## Requirements
- R1: After reset, every line of every cache reads as not present, and all four counters are zero.
- R2: The address splits into a word offset (low log2(LINE_WORDS) bits), a line index (next log2(NUM_LINES) bits) and a tag (remaining upper bits). Defaults are 16-bit addresses, 512 lines and 4 words per line. An access misses when the requester's line at that index is absent or holds a different tag, and each miss adds exactly one to the miss counter.
- R3: `shared_o` is high during an operation exactly when the requester misses and some other cache holds that index with the same tag.
- R4: On a miss with `shared_o` low, a read fills the line Exclusive and a write fills it Modified. On a miss with `shared_o` high, the requester fills the line Shared, remote copies in Exclusive or Modified move to Shared, and remote Shared copies stay Shared.
- R5: A remote Modified copy that snoops a miss to its line sends one data message, counted on `data_msg_cnt_o`.
- R6: A write miss with `shared_o` high broadcasts one update, and so does any write hit to a Shared line. Each broadcast adds one to `upd_bcast_cnt_o` and adds to `upd_lines_cnt_o` the number of other caches holding the line, which may be zero.
- R7: Read hits in Exclusive or Modified, and write hits in Modified, change nothing. A write hit in Exclusive moves the line to Modified silently. None of these touches any counter.
- R8: A miss that replaces a Modified line of a different tag sends one data message. Replacing an Exclusive or Shared line sends none.
- R9: A cycle with `op_valid_i` low changes no line and no counter.
- R10: The query port returns the tag and state of the selected line, with the state encoded as 0 not present, 1 Shared, 2 Exclusive, 3 Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_cpu_i | input | CPU_W | Requesting processor |
| op_write_i | input | 1 | 1 write, 0 read |
| op_addr_i | input | ADDR_W | Word address |
| shared_o | output | 1 | Wired-OR shared signal for the current operation |
| qry_cpu_i | input | CPU_W | Cache selected for query |
| qry_index_i | input | IDX_W | Line selected for query |
| qry_tag_o | output | TAG_W | Tag of queried line |
| qry_state_o | output | 2 | State of queried line |
| miss_cnt_o | output | CNT_W | Miss count |
| upd_bcast_cnt_o | output | CNT_W | Update broadcasts |
| upd_lines_cnt_o | output | CNT_W | Remote lines updated |
| data_msg_cnt_o | output | CNT_W | Data messages |

## Verification
The bench uses two addresses that share an index but differ in tag. With these it checks that a tag mismatch is a miss and that only Modified victims cost a write-back. A design that compared only the index would count hits instead. A write to a Shared line whose other sharers have all been evicted must still broadcast and must add zero updated lines. A design that made that broadcast conditional, or that counted sharers wrongly, would miscount. The bench also checks that a Shared line snooping another miss stays Shared and sends no data, and that a downgrade from Modified sends exactly one data message. It covers silent Exclusive-to-Modified writes and idle cycles carrying stray inputs.

// File: rtl/mes_pkg.sv
package mes_pkg;
  typedef enum logic [1:0] {
    LS_NONE = 2'd0,
    LS_SHR  = 2'd1,
    LS_EXC  = 2'd2,
    LS_MOD  = 2'd3
  } line_st_e;
endpackage

// File: rtl/mes_line_store.sv
module mes_line_store
  import mes_pkg::*;
#(
  parameter int NUM_LINES = 512,
  parameter int TAG_W     = 5,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  line_st_e         wr_st_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output line_st_e         rd_st_o,
  input  logic [IDX_W-1:0] q_idx_i,
  output logic [TAG_W-1:0] q_tag_o,
  output line_st_e         q_st_o
);
  line_st_e         st_q  [NUM_LINES];
  logic [TAG_W-1:0] tag_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_NONE;
    end else if (wr_en_i) begin
      st_q[idx_i] <= wr_st_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[idx_i] <= wr_tag_i;
  end

  assign rd_tag_o = tag_q[idx_i];
  assign rd_st_o  = st_q[idx_i];
  assign q_tag_o  = tag_q[q_idx_i];
  assign q_st_o   = st_q[q_idx_i];
endmodule

// File: rtl/mes_next_state.sv
module mes_next_state
  import mes_pkg::*;
(
  input  logic     is_req_i,
  input  logic     write_i,
  input  logic     match_i,
  input  logic     req_miss_i,
  input  logic     shared_i,
  input  line_st_e cur_st_i,
  output line_st_e nxt_st_o,
  output logic     upd_o,
  output logic     wb_o,
  output logic     bcast_o,
  output logic     miss_o
);
  always_comb begin
    nxt_st_o = cur_st_i;
    upd_o    = 1'b0;
    wb_o     = 1'b0;
    bcast_o  = 1'b0;
    miss_o   = 1'b0;
    if (is_req_i) begin
      if (match_i) begin
        if (write_i) begin
          if (cur_st_i == LS_SHR) bcast_o = 1'b1;
          if (cur_st_i == LS_EXC) begin
            nxt_st_o = LS_MOD;
            upd_o    = 1'b1;
          end
        end
      end else begin
        miss_o   = 1'b1;
        wb_o     = (cur_st_i == LS_MOD);   // victim write-back
        upd_o    = 1'b1;
        bcast_o  = write_i && shared_i;
        if (shared_i)     nxt_st_o = LS_SHR;
        else if (write_i) nxt_st_o = LS_MOD;
        else              nxt_st_o = LS_EXC;
      end
    end else if (req_miss_i && match_i) begin
      if (cur_st_i == LS_MOD || cur_st_i == LS_EXC) begin
        nxt_st_o = LS_SHR;
        upd_o    = 1'b1;
        wb_o     = (cur_st_i == LS_MOD);   // data write on downgrade
      end
    end
  end
endmodule

// File: rtl/mes_event_count.sv
module mes_event_count #(
  parameter int CNT_W = 32,
  parameter int ADD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             miss_i,
  input  logic             bcast_i,
  input  logic [ADD_W-1:0] lines_i,
  input  logic [ADD_W-1:0] data_i,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] bcast_cnt_o,
  output logic [CNT_W-1:0] lines_cnt_o,
  output logic [CNT_W-1:0] data_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_cnt_o  <= '0;
      bcast_cnt_o <= '0;
      lines_cnt_o <= '0;
      data_cnt_o  <= '0;
    end else if (en_i) begin
      miss_cnt_o <= miss_cnt_o + CNT_W'(miss_i);
      data_cnt_o <= data_cnt_o + CNT_W'(data_i);
      if (bcast_i) begin
        bcast_cnt_o <= bcast_cnt_o + CNT_W'(1);
        lines_cnt_o <= lines_cnt_o + CNT_W'(lines_i);
      end
    end
  end
endmodule

// File: rtl/mes_coherence.sv
module mes_coherence
  import mes_pkg::*;
#(
  parameter int N_CACHES   = 4,
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 512,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 32,
  localparam int CPU_W     = $clog2(N_CACHES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [CPU_W-1:0]  op_cpu_i,
  input  logic              op_write_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic              shared_o,
  input  logic [CPU_W-1:0]  qry_cpu_i,
  input  logic [IDX_W-1:0]  qry_index_i,
  output logic [TAG_W-1:0]  qry_tag_o,
  output logic [1:0]        qry_state_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  upd_bcast_cnt_o,
  output logic [CNT_W-1:0]  upd_lines_cnt_o,
  output logic [CNT_W-1:0]  data_msg_cnt_o
);
  localparam int SUM_W = $clog2(N_CACHES + 1);

  logic [IDX_W-1:0] op_idx;
  logic [TAG_W-1:0] op_tag;
  assign op_idx = op_addr_i[OFF_W +: IDX_W];
  assign op_tag = op_addr_i[ADDR_W-1 -: TAG_W];

  generate
    if (OFF_W > 0) begin : g_off
      logic unused_off;
      assign unused_off = ^op_addr_i[OFF_W-1:0];
    end
  endgenerate

  logic [N_CACHES-1:0] req_oh, match, remote, upd, wb, bc, ms;
  logic [TAG_W-1:0]    cur_tag [N_CACHES];
  logic [TAG_W-1:0]    q_tag   [N_CACHES];
  line_st_e            cur_st  [N_CACHES];
  line_st_e            nxt_st  [N_CACHES];
  line_st_e            q_st    [N_CACHES];
  logic                req_miss, shared;
  logic [SUM_W-1:0]    remote_cnt, data_cnt;

  assign remote   = match & ~req_oh;
  assign req_miss = op_valid_i && ((match & req_oh) == '0);
  assign shared   = req_miss && (remote != '0);
  assign shared_o = shared;

  always_comb begin
    remote_cnt = '0;
    data_cnt   = '0;
    for (int c = 0; c < N_CACHES; c++) begin
      remote_cnt = remote_cnt + SUM_W'(remote[c]);
      data_cnt   = data_cnt + SUM_W'(wb[c]);
    end
  end

  generate
    for (genvar c = 0; c < N_CACHES; c++) begin : g_cache
      assign req_oh[c] = (op_cpu_i == CPU_W'(c));
      assign match[c]  = (cur_st[c] != LS_NONE) && (cur_tag[c] == op_tag);

      mes_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) i_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (op_valid_i && upd[c]),
        .idx_i    (op_idx),
        .wr_tag_i (op_tag),
        .wr_st_i  (nxt_st[c]),
        .rd_tag_o (cur_tag[c]),
        .rd_st_o  (cur_st[c]),
        .q_idx_i  (qry_index_i),
        .q_tag_o  (q_tag[c]),
        .q_st_o   (q_st[c])
      );

      mes_next_state i_ns (
        .is_req_i   (req_oh[c]),
        .write_i    (op_write_i),
        .match_i    (match[c]),
        .req_miss_i (req_miss),
        .shared_i   (shared),
        .cur_st_i   (cur_st[c]),
        .nxt_st_o   (nxt_st[c]),
        .upd_o      (upd[c]),
        .wb_o       (wb[c]),
        .bcast_o    (bc[c]),
        .miss_o     (ms[c])
      );
    end
  endgenerate

  assign qry_tag_o   = q_tag[qry_cpu_i];
  assign qry_state_o = q_st[qry_cpu_i];

  mes_event_count #(.CNT_W(CNT_W), .ADD_W(SUM_W)) i_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (op_valid_i),
    .miss_i      (|ms),
    .bcast_i     (|bc),
    .lines_i     (remote_cnt),
    .data_i      (data_cnt),
    .miss_cnt_o  (miss_cnt_o),
    .bcast_cnt_o (upd_bcast_cnt_o),
    .lines_cnt_o (upd_lines_cnt_o),
    .data_cnt_o  (data_msg_cnt_o)
  );
endmodule

// File: rtl/mes_coherence_chk.sv
module mes_coherence_chk #(
  parameter int N_CACHES = 4,
  parameter int CNT_W    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic             shared_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [CNT_W-1:0] upd_bcast_cnt_o,
  input logic [CNT_W-1:0] upd_lines_cnt_o,
  input logic [CNT_W-1:0] data_msg_cnt_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(miss_cnt_o) && $stable(upd_bcast_cnt_o)
                    && $stable(upd_lines_cnt_o) && $stable(data_msg_cnt_o)); // R9

  AST_MISS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (miss_cnt_o == $past(miss_cnt_o))
                   || (miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1))); // R2

  AST_SHARED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> op_valid_i); // R3

  AST_SHARED_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |=> miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1)); // R3

  AST_LINES_NEED_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (upd_lines_cnt_o == $past(upd_lines_cnt_o))
                   || (upd_bcast_cnt_o == $past(upd_bcast_cnt_o) + CNT_W'(1))); // R6

  AST_LINES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (upd_lines_cnt_o - $past(upd_lines_cnt_o)) <= CNT_W'(N_CACHES - 1)); // R6

  AST_DATA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (data_msg_cnt_o - $past(data_msg_cnt_o)) <= CNT_W'(2)); // R5
endmodule

bind mes_coherence mes_coherence_chk #(.N_CACHES(N_CACHES), .CNT_W(CNT_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .op_valid_i      (op_valid_i),
  .shared_o        (shared_o),
  .miss_cnt_o      (miss_cnt_o),
  .upd_bcast_cnt_o (upd_bcast_cnt_o),
  .upd_lines_cnt_o (upd_lines_cnt_o),
  .data_msg_cnt_o  (data_msg_cnt_o)
);

// File: tb/test_mes_coherence.sv
module test_mes_coherence;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_cpu = '0;
  logic        op_write = 1'b0;
  logic [15:0] op_addr = '0;
  logic        shared;
  logic [1:0]  qry_cpu = '0;
  logic [8:0]  qry_index = '0;
  logic [4:0]  qry_tag;
  logic [1:0]  qry_state;
  logic [31:0] miss_cnt, bcast_cnt, lines_cnt, data_cnt;

  int n_chk = 0, n_fail = 0;
  int e_miss = 0, e_bc = 0, e_ln = 0, e_dt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mes_coherence i_mes_coherence (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_cpu_i(op_cpu),
    .op_write_i(op_write), .op_addr_i(op_addr), .shared_o(shared),
    .qry_cpu_i(qry_cpu), .qry_index_i(qry_index), .qry_tag_o(qry_tag),
    .qry_state_o(qry_state), .miss_cnt_o(miss_cnt), .upd_bcast_cnt_o(bcast_cnt),
    .upd_lines_cnt_o(lines_cnt), .data_msg_cnt_o(data_cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cnt(string req);
    chk(req, "miss count", int'(miss_cnt), e_miss);
    chk(req, "update broadcasts", int'(bcast_cnt), e_bc);
    chk(req, "lines updated", int'(lines_cnt), e_ln);
    chk(req, "data messages", int'(data_cnt), e_dt);
  endtask

  // issue one op; returns with counters settled, at a falling edge
  task automatic op(input int cpu, input bit wr, input int addr, output bit sh);
    @(negedge clk);
    op_valid = 1'b1; op_cpu = 2'(cpu); op_write = wr; op_addr = 16'(addr);
    #2 sh = shared;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic look(string req, int cpu, int idx, int exp_st, int exp_tag);
    qry_cpu = 2'(cpu); qry_index = 9'(idx);
    #1;
    chk(req, $sformatf("state P%0d line %0d", cpu, idx), int'(qry_state), exp_st);
    if (exp_st != 0)
      chk(req, $sformatf("tag P%0d line %0d", cpu, idx), int'(qry_tag), exp_tag);
  endtask

  task automatic t_reset;
    chk_cnt("R1");
    for (int c = 0; c < 4; c++) look("R1", c, 4, 0, 0);
  endtask

  task automatic t_private_fill;
    bit sh;
    op(0, 0, 'h0010, sh); e_miss++;
    chk("R3", "shared on lone read miss", sh, 0);
    look("R4", 0, 4, 2, 0);
    op(2, 1, 'h0100, sh); e_miss++;
    chk("R3", "shared on lone write miss", sh, 0);
    look("R4", 2, 64, 3, 0);
    chk_cnt("R2");
  endtask

  task automatic t_shared_fill;
    bit sh;
    op(1, 0, 'h0011, sh); e_miss++;
    chk("R3", "shared on read miss with holder", sh, 1);
    look("R4", 0, 4, 1, 0);
    look("R4", 1, 4, 1, 0);
    chk_cnt("R4");
  endtask

  task automatic t_silent_hits;
    bit sh;
    op(2, 1, 'h0101, sh);
    chk("R3", "shared on hit", sh, 0);
    op(2, 0, 'h0102, sh);
    look("R7", 2, 64, 3, 0);
    op(3, 0, 'h0300, sh); e_miss++;
    op(3, 0, 'h0301, sh);
    look("R7", 3, 192, 2, 0);
    op(3, 1, 'h0302, sh);
    look("R7", 3, 192, 3, 0);
    chk_cnt("R7");
  endtask

  task automatic t_mod_snoop;
    bit sh;
    op(1, 0, 'h0103, sh); e_miss++; e_dt++;
    chk("R5", "shared on snoop of modified", sh, 1);
    look("R5", 2, 64, 1, 0);
    look("R4", 1, 64, 1, 0);
    chk_cnt("R5");
  endtask

  task automatic t_shared_write;
    bit sh;
    op(1, 1, 'h0012, sh); e_bc++; e_ln += 1;
    look("R6", 0, 4, 1, 0);
    look("R6", 1, 4, 1, 0);
    chk_cnt("R6");
    op(0, 0, 'h0100, sh); e_miss++;
    look("R4", 1, 64, 1, 0);
    look("R4", 2, 64, 1, 0);
    look("R4", 0, 64, 1, 0);
    op(2, 1, 'h0100, sh); e_bc++; e_ln += 2;
    chk_cnt("R6");
  endtask

  task automatic t_write_miss_shared;
    bit sh;
    op(0, 0, 'h0200, sh); e_miss++;
    op(1, 1, 'h0201, sh); e_miss++; e_bc++; e_ln += 1;
    chk("R3", "shared on write miss with holder", sh, 1);
    look("R4", 1, 128, 1, 0);
    look("R4", 0, 128, 1, 0);
    chk_cnt("R6");
  endtask

  task automatic t_evict;
    bit sh;
    op(2, 1, 'h0400, sh); e_miss++;
    op(2, 0, 'h0C00, sh); e_miss++; e_dt++;
    look("R8", 2, 256, 2, 1);
    chk_cnt("R8");
    op(2, 0, 'h1400, sh); e_miss++;
    look("R8", 2, 256, 2, 2);
    op(1, 0, 'h0810, sh); e_miss++;
    chk("R3", "shared with other tag at index", sh, 0);
    look("R2", 1, 4, 2, 1);
    look("R2", 0, 4, 1, 0);
    chk_cnt("R8");
  endtask

  task automatic t_lone_sharer;
    bit sh;
    op(0, 1, 'h0010, sh); e_bc++;
    look("R6", 0, 4, 1, 0);
    chk_cnt("R6");
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_cpu = 2'd3; op_write = 1'b1; op_addr = 16'h0010;
    repeat (3) @(negedge clk);
    look("R9", 3, 4, 0, 0);
    look("R9", 0, 4, 1, 0);
    chk_cnt("R9");
  endtask

  task automatic t_query;
    look("R10", 1, 4, 2, 1);
    look("R10", 3, 192, 3, 0);
    look("R10", 2, 128, 0, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_private_fill();
    t_shared_fill();
    t_silent_hits();
    t_mod_snoop();
    t_shared_write();
    t_write_miss_shared();
    t_evict();
    t_lone_sharer();
    t_idle();
    t_query();
    finish_run();
  end
endmodule